// File: doc/BRIEF.md
# Halt-Mode Power Sequencer

This controller takes a small microcontroller into and out of its low-power halt states. It runs from an always-on clock. When the CPU asks to halt, the controller picks one of two halt flavours from the oscillator interrupt enable. A full halt stops the main oscillator and every clock. An active halt keeps only the main oscillator and its time-base counter alive. A full halt requested while the watchdog is running, and while the option bit forbids that combination, does not halt at all: the controller answers with a watchdog reset.

Once the controller is halted, it watches the wake sources. The reset input, the external interrupt and the halt-exit-capable internal interrupt wake either flavour. The oscillator time-base interrupt wakes only an active halt, which puts an upper bound on the time spent there. A wake turns the oscillator back on at once, then holds the CPU and peripheral clocks off for a fixed stabilization window. When the window closes, the controller tells the CPU either to fetch the reset vector or to push its condition codes and service the interrupt. The oscillator, the watchdog counter, the stack push and the vectoring logic stay outside this block and are seen only as ports.

There are four states. RUN (mode 00) is normal operation. HALT_STD (mode 01) is the full halt. HALT_ACT (mode 10) is the active halt. STAB (mode 11) is the stabilization window. The transitions are:
- RUN to HALT_STD on a request with the interrupt enable clear and no watchdog conflict.
- RUN to HALT_ACT on a request with the interrupt enable set.
- RUN to RUN, with a watchdog reset, on a conflicting full-halt request.
- HALT_STD or HALT_ACT to STAB on a wake.
- STAB to RUN when the count completes.

Top module: `pwr_halt_seq`

## Requirements
- R1: After a halt request in RUN with `osc_irq_en_i`=0, and with either `wdg_en_i`=0 or `wdg_halt_ok_i`=1, the next cycle shows mode 01 with all four enables (`osc_en_o`, `tb_en_o`, `cpu_clk_en_o`, `per_clk_en_o`) low.
- R2: After a halt request in RUN with `osc_irq_en_i`=1, the next cycle shows mode 10 with the oscillator and time-base enables high and the CPU and peripheral enables low. No watchdog reset is issued, whatever the state of the watchdog inputs.
- R3: A halt request in RUN with `osc_irq_en_i`=0, `wdg_en_i`=1 and `wdg_halt_ok_i`=0 keeps the mode at 00 and produces a one-cycle `wdg_rst_o` pulse in the following cycle.
- R4: Entering either halt mode produces a one-cycle `irq_mask_clr_o` pulse in the first halted cycle. The pulse appears at no other time.
- R5: In mode 01, a wake comes from `sys_reset_i`, `ext_irq_i` or `int_irq_i`. `osc_tb_irq_i` has no effect in mode 01.
- R6: In mode 10, `osc_tb_irq_i` is also a wake source, alongside the three sources of R5.
- R7: A wake sampled at a clock edge puts the controller in mode 11 for exactly 4096 cycles. During that window the oscillator and time-base enables are high and the CPU and peripheral enables are low. Mode 00 follows, with all enables high.
- R8: In the first RUN cycle after the stabilization window, the exit outcome is signalled by pulses. For a reset cause, `fetch_rst_vec_o` pulses for one cycle. Otherwise `cc_push_o` pulses for one cycle and `irq_serve_o` pulses in the cycle after that.
- R9: Reset takes priority over interrupts. This holds when a reset arrives together with an interrupt as the wake, and when a reset arrives during the stabilization window. In both cases the exit is a reset-vector fetch.
- R10: Halt requests are ignored in every state other than RUN. For example, a request made during mode 11 neither changes the mode nor shortens the window.
- R11: After reset the mode is 00, all four enables are high, and every pulse output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Active-low asynchronous reset of the controller |
| halt_req_i | input | 1 | Halt request from the CPU |
| osc_irq_en_i | input | 1 | Oscillator interrupt enable; 1 selects active halt |
| wdg_en_i | input | 1 | Watchdog running |
| wdg_halt_ok_i | input | 1 | Option bit: 1 allows a full halt while the watchdog runs |
| sys_reset_i | input | 1 | Reset wake source |
| ext_irq_i | input | 1 | External interrupt wake source |
| int_irq_i | input | 1 | Internal interrupt able to exit halt |
| osc_tb_irq_i | input | 1 | Oscillator time-base interrupt |
| osc_en_o | output | 1 | Main oscillator enable |
| tb_en_o | output | 1 | Time-base counter enable |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| per_clk_en_o | output | 1 | Peripheral clock enable |
| wdg_rst_o | output | 1 | One-cycle watchdog reset pulse |
| irq_mask_clr_o | output | 1 | One-cycle request to clear the CPU interrupt mask |
| fetch_rst_vec_o | output | 1 | One-cycle pulse: fetch the reset vector |
| cc_push_o | output | 1 | One-cycle pulse: push the condition codes |
| irq_serve_o | output | 1 | One-cycle pulse: service the interrupt |
| mode_o | output | 2 | 00 run, 01 full halt, 10 active halt, 11 stabilizing |

## Verification
Every result here sits one register behind its stimulus, so the bench drives on the falling edge and samples on the next falling edge. At that point a halt request shows up in the mode, the enables, `wdg_rst_o` and `irq_mask_clr_o`. A wake shows up as mode 11 one half-cycle after the edge that sampled it. The bench then counts 4095 further falling edges to confirm mode 11 still holds, and one more to see RUN together with `fetch_rst_vec_o` or `cc_push_o`. `irq_serve_o` is checked one cycle after that. The mid-window reset and the ignored halt request are placed at a known count inside the window, so the final edge stays at the same fixed offset from the wake.

// File: rtl/pwr_halt_pkg.sv
package pwr_halt_pkg;

    typedef enum logic [1:0] {
        PH_RUN  = 2'b00,
        PH_STD  = 2'b01,
        PH_ACT  = 2'b10,
        PH_STAB = 2'b11
    } ph_state_e;

endpackage

// File: rtl/pwr_halt_decide.sv
// Chooses the halt flavour for a request, or the watchdog-conflict reset.
module pwr_halt_decide (
    input  logic osc_irq_en,
    input  logic wdg_en,
    input  logic wdg_halt_ok,
    output logic go_std,
    output logic go_act,
    output logic force_rst
);
    always_comb begin
        go_act    = osc_irq_en;
        force_rst = !osc_irq_en && wdg_en && !wdg_halt_ok;
        go_std    = !osc_irq_en && !force_rst;
    end
endmodule

// File: rtl/pwr_wake_detect.sv
// Qualifies wake sources for the current halt flavour.
module pwr_wake_detect (
    input  logic in_std,
    input  logic in_act,
    input  logic sys_reset,
    input  logic ext_irq,
    input  logic int_irq,
    input  logic osc_tb_irq,
    output logic wake,
    output logic wake_by_rst
);
    logic halted;

    always_comb begin
        halted      = in_std || in_act;
        wake        = (halted && (sys_reset || ext_irq || int_irq))
                    || (in_act && osc_tb_irq);
        wake_by_rst = halted && sys_reset;
    end
endmodule

// File: rtl/pwr_stab_timer.sv
// Stabilization counter: cleared by the wake, counts while active,
// reports done in the last counted cycle.
module pwr_stab_timer #(
    parameter int unsigned STAB_CYCLES = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic active,
    output logic done
);
    localparam int unsigned CW = (STAB_CYCLES > 1) ? $clog2(STAB_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(STAB_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (active) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done = active && (cnt_q == LAST);
endmodule

// File: rtl/pwr_halt_seq.sv
module pwr_halt_seq
    import pwr_halt_pkg::*;
#(
    parameter int unsigned STAB_CYCLES = 4096
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       halt_req_i,
    input  logic       osc_irq_en_i,
    input  logic       wdg_en_i,
    input  logic       wdg_halt_ok_i,
    input  logic       sys_reset_i,
    input  logic       ext_irq_i,
    input  logic       int_irq_i,
    input  logic       osc_tb_irq_i,
    output logic       osc_en_o,
    output logic       tb_en_o,
    output logic       cpu_clk_en_o,
    output logic       per_clk_en_o,
    output logic       wdg_rst_o,
    output logic       irq_mask_clr_o,
    output logic       fetch_rst_vec_o,
    output logic       cc_push_o,
    output logic       irq_serve_o,
    output logic [1:0] mode_o
);
    ph_state_e state_q, state_d;

    logic go_std, go_act, force_rst;
    logic wake, wake_by_rst, stab_done;
    logic in_run, in_stab, rst_cause;
    logic rst_flag_q, wdg_rst_q, mask_clr_q, fetch_q, cc_push_q, serve_q;

    assign in_run  = (state_q == PH_RUN);
    assign in_stab = (state_q == PH_STAB);

    pwr_halt_decide u_decide (
        .osc_irq_en  (osc_irq_en_i),
        .wdg_en      (wdg_en_i),
        .wdg_halt_ok (wdg_halt_ok_i),
        .go_std      (go_std),
        .go_act      (go_act),
        .force_rst   (force_rst)
    );

    pwr_wake_detect u_wake (
        .in_std      (state_q == PH_STD),
        .in_act      (state_q == PH_ACT),
        .sys_reset   (sys_reset_i),
        .ext_irq     (ext_irq_i),
        .int_irq     (int_irq_i),
        .osc_tb_irq  (osc_tb_irq_i),
        .wake        (wake),
        .wake_by_rst (wake_by_rst)
    );

    pwr_stab_timer #(.STAB_CYCLES(STAB_CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (wake),
        .active (in_stab),
        .done   (stab_done)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_RUN: begin
                if (halt_req_i && go_act)      state_d = PH_ACT;
                else if (halt_req_i && go_std) state_d = PH_STD;
            end
            PH_STD, PH_ACT: begin
                if (wake) state_d = PH_STAB;
            end
            PH_STAB: begin
                if (stab_done) state_d = PH_RUN;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PH_RUN;
        else        state_q <= state_d;
    end

    // Reset wins over any interrupt cause, including one arriving late in the window
    assign rst_cause = rst_flag_q || sys_reset_i;

    // Registered pulse outputs and wake-cause record
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rst_flag_q <= 1'b0;
            wdg_rst_q  <= 1'b0;
            mask_clr_q <= 1'b0;
            fetch_q    <= 1'b0;
            cc_push_q  <= 1'b0;
            serve_q    <= 1'b0;
        end else begin
            if (wake)                        rst_flag_q <= wake_by_rst;
            else if (in_stab && sys_reset_i) rst_flag_q <= 1'b1;
            wdg_rst_q  <= in_run && halt_req_i && force_rst;
            mask_clr_q <= in_run && halt_req_i && (go_std || go_act);
            fetch_q    <= stab_done && rst_cause;
            cc_push_q  <= stab_done && !rst_cause;
            serve_q    <= cc_push_q;
        end
    end

    // Clock enables decoded from state
    always_comb begin
        unique case (state_q)
            PH_RUN:  {osc_en_o, tb_en_o, cpu_clk_en_o, per_clk_en_o} = 4'b1111;
            PH_STD:  {osc_en_o, tb_en_o, cpu_clk_en_o, per_clk_en_o} = 4'b0000;
            PH_ACT:  {osc_en_o, tb_en_o, cpu_clk_en_o, per_clk_en_o} = 4'b1100;
            PH_STAB: {osc_en_o, tb_en_o, cpu_clk_en_o, per_clk_en_o} = 4'b1100;
        endcase
    end

    assign mode_o          = state_q;
    assign wdg_rst_o       = wdg_rst_q;
    assign irq_mask_clr_o  = mask_clr_q;
    assign fetch_rst_vec_o = fetch_q;
    assign cc_push_o       = cc_push_q;
    assign irq_serve_o     = serve_q;
endmodule

// File: rtl/pwr_halt_seq_chk.sv
module pwr_halt_seq_chk #(
    parameter int unsigned STAB_CYCLES = 4096
) (
    input logic       clk,
    input logic       rst_n,
    input logic       halt_req_i,
    input logic       osc_irq_en_i,
    input logic       wdg_en_i,
    input logic       wdg_halt_ok_i,
    input logic       osc_en_o,
    input logic       tb_en_o,
    input logic       cpu_clk_en_o,
    input logic       per_clk_en_o,
    input logic       wdg_rst_o,
    input logic       irq_mask_clr_o,
    input logic       fetch_rst_vec_o,
    input logic       cc_push_o,
    input logic       irq_serve_o,
    input logic [1:0] mode_o
);
    localparam int unsigned SW = $clog2(STAB_CYCLES + 1) + 1;

    logic [SW-1:0] stab_len_q;
    logic [3:0]    en;

    assign en = {osc_en_o, tb_en_o, cpu_clk_en_o, per_clk_en_o};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               stab_len_q <= '0;
        else if (mode_o == 2'b11) stab_len_q <= stab_len_q + 1'b1;
        else                      stab_len_q <= '0;
    end

    assert_std_all_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'b01) |-> (en == 4'b0000));

    assert_act_enables_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'b10) |-> (en == 4'b1100));

    assert_act_no_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'b00 && halt_req_i && osc_irq_en_i) |=> (mode_o == 2'b10 && !wdg_rst_o));

    assert_wdg_conflict_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'b00 && halt_req_i && !osc_irq_en_i && wdg_en_i && !wdg_halt_ok_i)
        |=> (mode_o == 2'b00 && wdg_rst_o));

    assert_mask_clr_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_mask_clr_o |-> ((mode_o == 2'b01 || mode_o == 2'b10) && $past(mode_o) == 2'b00));

    assert_stab_enables_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'b11) |-> (en == 4'b1100));

    assert_stab_length_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode_o) == 2'b11 && mode_o == 2'b00) |-> (stab_len_q == SW'(STAB_CYCLES)));

    assert_push_then_serve_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cc_push_o |=> (irq_serve_o && !fetch_rst_vec_o));

    assert_fetch_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_rst_vec_o |-> (!cc_push_o && !irq_serve_o && mode_o == 2'b00));

    assert_stab_ignores_halt_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'b11 && halt_req_i) |=> (mode_o == 2'b11 || mode_o == 2'b00));

    assert_run_enables_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'b00) |-> (en == 4'b1111));
endmodule

bind pwr_halt_seq pwr_halt_seq_chk #(.STAB_CYCLES(STAB_CYCLES)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .halt_req_i      (halt_req_i),
    .osc_irq_en_i    (osc_irq_en_i),
    .wdg_en_i        (wdg_en_i),
    .wdg_halt_ok_i   (wdg_halt_ok_i),
    .osc_en_o        (osc_en_o),
    .tb_en_o         (tb_en_o),
    .cpu_clk_en_o    (cpu_clk_en_o),
    .per_clk_en_o    (per_clk_en_o),
    .wdg_rst_o       (wdg_rst_o),
    .irq_mask_clr_o  (irq_mask_clr_o),
    .fetch_rst_vec_o (fetch_rst_vec_o),
    .cc_push_o       (cc_push_o),
    .irq_serve_o     (irq_serve_o),
    .mode_o          (mode_o)
);

// File: tb/pwr_halt_seq_bench.sv
`timescale 1ns/1ps
module pwr_halt_seq_bench;
    localparam int STAB = 4096;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic halt_req = 0, oie = 0, wdg_en = 0, wdg_ok = 0;
    logic sys_rst = 0, ext_irq = 0, int_irq = 0, tb_irq = 0;
    logic osc_en, tb_en, cpu_en, per_en, wdg_rst, mask_clr, fetch, cc_push, serve;
    logic [1:0] mode;
    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    pwr_halt_seq #(.STAB_CYCLES(STAB)) u_pwr_halt_seq (
        .clk(clk), .rst_n(rst_n), .halt_req_i(halt_req), .osc_irq_en_i(oie),
        .wdg_en_i(wdg_en), .wdg_halt_ok_i(wdg_ok), .sys_reset_i(sys_rst),
        .ext_irq_i(ext_irq), .int_irq_i(int_irq), .osc_tb_irq_i(tb_irq),
        .osc_en_o(osc_en), .tb_en_o(tb_en), .cpu_clk_en_o(cpu_en), .per_clk_en_o(per_en),
        .wdg_rst_o(wdg_rst), .irq_mask_clr_o(mask_clr), .fetch_rst_vec_o(fetch),
        .cc_push_o(cc_push), .irq_serve_o(serve), .mode_o(mode)
    );

    function automatic logic [3:0] enables();
        return {osc_en, tb_en, cpu_en, per_en};
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Request a halt for one cycle; returns at the falling edge after the sampling edge
    task automatic req_halt(input logic o, input logic w, input logic k);
        oie = o; wdg_en = w; wdg_ok = k; halt_req = 1'b1;
        @(negedge clk);
        halt_req = 1'b0;
    endtask

    // Apply wake inputs for one cycle, then check the first window cycle
    task automatic wake_with(input string tag, input logic r, input logic e, input logic i, input logic t);
        sys_rst = r; ext_irq = e; int_irq = i; tb_irq = t;
        @(negedge clk);
        sys_rst = 0; ext_irq = 0; int_irq = 0; tb_irq = 0;
        chk({tag, " mode after wake"}, mode, 8'h3);
        chk("R7 window enables", enables(), 8'hC);
    endtask

    // Finish the window from count 'done_k' and check the exit outcome
    task automatic drain(input int done_k, input logic exp_rst);
        repeat (STAB - 1 - done_k) @(negedge clk);
        chk("R7 still stabilizing at 4095", mode, 8'h3);
        @(negedge clk);
        chk("R7 run after 4096", mode, 8'h0);
        chk("R7 run enables", enables(), 8'hF);
        chk(exp_rst ? "R9 fetch reset vector" : "R8 fetch reset vector", fetch, {7'd0, exp_rst});
        chk("R8 condition push", cc_push, {7'd0, !exp_rst});
        chk("R8 serve not yet", serve, 8'h0);
        @(negedge clk);
        chk("R8 serve follows push", serve, {7'd0, !exp_rst});
        chk("R8 pulses single", {fetch, cc_push}, 8'h0);
    endtask

    task automatic t_reset();
        chk("R11 mode", mode, 8'h0);
        chk("R11 enables", enables(), 8'hF);
        chk("R11 pulses", {wdg_rst, mask_clr, fetch, cc_push, serve}, 8'h0);
    endtask

    task automatic t_std_halt();
        req_halt(0, 0, 0);
        chk("R1 mode", mode, 8'h1);
        chk("R1 enables", enables(), 8'h0);
        chk("R4 mask clear", mask_clr, 8'h1);
        @(negedge clk);
        chk("R4 mask clear one cycle", mask_clr, 8'h0);
        tb_irq = 1'b1;
        @(negedge clk);
        tb_irq = 1'b0;
        @(negedge clk);
        chk("R5 time-base ignored in full halt", mode, 8'h1);
        wake_with("R5", 0, 1, 0, 0);
        drain(0, 1'b0);
    endtask

    task automatic t_act_halt();
        req_halt(1, 1, 0);
        chk("R2 mode", mode, 8'h2);
        chk("R2 enables", enables(), 8'hC);
        chk("R2 no watchdog reset", wdg_rst, 8'h0);
        chk("R4 mask clear active", mask_clr, 8'h1);
        repeat (3) @(negedge clk);
        chk("R2 holds", mode, 8'h2);
        wake_with("R6", 0, 0, 0, 1);
        drain(0, 1'b0);
    endtask

    task automatic t_wdg_conflict();
        req_halt(0, 1, 0);
        chk("R3 watchdog reset", wdg_rst, 8'h1);
        chk("R3 stays run", mode, 8'h0);
        chk("R3 enables", enables(), 8'hF);
        chk("R4 no mask clear", mask_clr, 8'h0);
        @(negedge clk);
        chk("R3 pulse one cycle", wdg_rst, 8'h0);
    endtask

    task automatic t_opt_allows();
        req_halt(0, 1, 1);
        chk("R1 option allows halt", mode, 8'h1);
        chk("R3 no reset with option", wdg_rst, 8'h0);
        wake_with("R5 internal", 0, 0, 1, 0);
        drain(0, 1'b0);
        req_halt(0, 0, 0);
        wake_with("R5 reset", 1, 0, 0, 0);
        drain(0, 1'b1);
    endtask

    task automatic t_both_wake();
        req_halt(0, 0, 0);
        wake_with("R9 simultaneous", 1, 1, 0, 0);
        drain(0, 1'b1);
    endtask

    task automatic t_rst_in_window();
        req_halt(1, 0, 0);
        wake_with("R6 external in active", 0, 1, 0, 0);
        repeat (99) @(negedge clk);
        sys_rst = 1'b1; halt_req = 1'b1;
        @(negedge clk);
        sys_rst = 1'b0; halt_req = 1'b0;
        chk("R10 halt ignored in window", mode, 8'h3);
        drain(100, 1'b1);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_std_halt();
        t_act_halt();
        t_wdg_conflict();
        t_opt_allows();
        t_both_wake();
        t_rst_in_window();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule